// File: doc/BRIEF.md
# Command-Driven I2C Byte Master

This block is a single-master I2C engine that a host sequencer steps through a bus transaction one primitive at a time. The host pulls one of three active-low request lines low: one for a start condition, one for a single byte transfer, and one for a stop condition. A direction input picks whether a byte is written to the slave or read from it. When the requested primitive has finished, the engine lowers its active-low completion flag. The flag stays low until the host has released every request line.

SCL is generated from the system clock by a divider. Each SCL half-period lasts a fixed number of divided ticks. SDA comes out as a driven value plus an active-low output-enable, and the resolved line is fed back on a separate input. This lets the engine sample the slave's acknowledge bit and read data. The engine does not arbitrate between masters and does not honour clock stretching.

Top module: `i2cm_byte_engine`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `scl`, `sda_out`, `sda_oe_n`, `ack` and `done_n` are 1 and `rd_data` is 0.
- R2: A start request makes SDA fall while SCL is high. SCL then falls, and after that `done_n` goes low.
- R3: A write transfer (`rd_wr`=0) drives the 8 bits of `wr_data` most-significant first, with `sda_oe_n`=0. Each bit is held stable for the whole high time of its SCL pulse.
- R4: A transfer always issues a ninth SCL pulse with `sda_oe_n`=1. The `sda_in` value sampled during that high phase appears on `ack` (0 = acknowledged).
- R5: A read transfer (`rd_wr`=1) keeps `sda_oe_n`=1 for all nine SCL pulses. It assembles the eight sampled bits MSB-first and presents them on `rd_data` when the transfer completes.
- R6: A stop request raises SCL while SDA is low, then raises SDA while SCL is high, leaving both lines at 1.
- R7: `done_n` stays low as long as any request line is low. It returns to 1 on the clock edge after all three request lines are high.
- R8: Requests that arrive while a primitive is in progress are ignored. They add no start or stop condition and do not alter the byte on the bus.
- R9: When several requests are low together in the idle state, start wins over transfer, and transfer wins over stop.
- R10: SCL changes only on a divider tick, so each SCL level lasts at least `DIV` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_n | input | 1 | Active-low start-condition request |
| xfer_n | input | 1 | Active-low byte-transfer request |
| stop_n | input | 1 | Active-low stop-condition request |
| rd_wr | input | 1 | Transfer direction: 1 read, 0 write |
| wr_data | input | 8 | Byte to send on a write |
| sda_in | input | 1 | Resolved SDA line level |
| rd_data | output | 8 | Byte received by the last read |
| ack | output | 1 | Level sampled on the ninth SCL pulse |
| done_n | output | 1 | Active-low completion flag |
| scl | output | 1 | Serial clock |
| sda_out | output | 1 | Value driven onto SDA when enabled |
| sda_oe_n | output | 1 | Active-low SDA output enable (1 = released) |

## Verification
The checks assume that `sda_in` equals `sda_out` whenever `sda_oe_n` is low. They also assume the host holds a request low at least until `done_n` falls. The bench models the line as exactly that resolution. Its slave changes the bit it presents only after an observed SCL falling edge, so read data and acknowledge are stable while SCL is high. Requests are applied and released on the falling clock edge, and the bench waits for `done_n` before releasing them. The one exception is the deliberate extra pulses in the ignore scenario, which fall entirely inside a busy interval.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_XFER,
    ST_STOP,
    ST_WAIT
  } i2cm_state_t;
endpackage

// File: rtl/i2cm_tick.sv
// Free-running divider: one-cycle pulse every DIV system clocks.
module i2cm_tick #(
  parameter int DIV = 32
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2cm_shreg.sv
// Byte shifter: rotates left on write, shifts the line in at bit 0 on read.
module i2cm_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         dir_rd,
  input  logic         bit_in,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= dir_rd ? {q[W-2:0], bit_in} : {q[W-2:0], q[W-1]};
  end
endmodule

// File: rtl/i2cm_seq.sv
// Primitive sequencer: request accept, phase stepping, line control, completion.
module i2cm_seq
  import i2cm_pkg::*;
#(
  parameter int NBITS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic start_n,
  input  logic xfer_n,
  input  logic stop_n,
  input  logic rd_wr,
  input  logic sda_in,
  input  logic sr_msb,
  output logic scl,
  output logic sda_out,
  output logic sda_oe_n,
  output logic ack,
  output logic done_n,
  output logic load,
  output logic shift,
  output logic dir_rd,
  output logic cap,
  output logic xfer_act
);
  localparam int SW = $clog2(NBITS + 1);
  localparam logic [SW-1:0] ACK_SLOT = SW'(NBITS);

  i2cm_state_t st;
  logic [1:0]    ph;
  logic [SW-1:0] slot;
  logic          all_high;

  assign all_high = start_n && xfer_n && stop_n;
  assign load     = (st == ST_IDLE) && start_n && !xfer_n;
  assign shift    = tick && (st == ST_XFER) && (ph == 2'd2) && (slot != ACK_SLOT);
  assign cap      = tick && (st == ST_XFER) && (ph == 2'd2) && (slot == ACK_SLOT);
  assign xfer_act = (st == ST_XFER);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ph       <= 2'd0;
      slot     <= '0;
      scl      <= 1'b1;
      sda_out  <= 1'b1;
      sda_oe_n <= 1'b1;
      ack      <= 1'b1;
      done_n   <= 1'b1;
      dir_rd   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          ph   <= 2'd0;
          slot <= '0;
          if (!start_n) st <= ST_START;
          else if (!xfer_n) begin
            st     <= ST_XFER;
            dir_rd <= rd_wr;
          end else if (!stop_n) st <= ST_STOP;
        end
        ST_START: if (tick) begin
          ph <= ph + 2'd1;
          case (ph)
            2'd0: begin sda_out <= 1'b1; sda_oe_n <= 1'b0; end
            2'd1: scl <= 1'b1;
            2'd2: sda_out <= 1'b0;
            default: begin
              scl    <= 1'b0;
              st     <= ST_WAIT;
              done_n <= 1'b0;
            end
          endcase
        end
        ST_XFER: if (tick) begin
          case (ph)
            2'd0: begin
              scl <= 1'b0;
              ph  <= 2'd1;
              if (dir_rd || slot == ACK_SLOT) begin
                sda_oe_n <= 1'b1;
                sda_out  <= 1'b1;
              end else begin
                sda_oe_n <= 1'b0;
                sda_out  <= sr_msb;
              end
            end
            2'd1: begin
              scl <= 1'b1;
              ph  <= 2'd2;
            end
            default: begin
              scl <= 1'b0;
              ph  <= 2'd0;
              if (slot == ACK_SLOT) begin
                ack    <= sda_in;
                st     <= ST_WAIT;
                done_n <= 1'b0;
              end else begin
                slot <= slot + 1'b1;
              end
            end
          endcase
        end
        ST_STOP: if (tick) begin
          ph <= ph + 2'd1;
          case (ph)
            2'd0: begin scl <= 1'b0; sda_out <= 1'b0; sda_oe_n <= 1'b0; end
            2'd1: scl <= 1'b1;
            default: begin
              sda_out  <= 1'b1;
              sda_oe_n <= 1'b1;
              st       <= ST_WAIT;
              done_n   <= 1'b0;
            end
          endcase
        end
        default: begin
          if (all_high) begin
            done_n <= 1'b1;
            st     <= ST_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/i2cm_byte_engine.sv
module i2cm_byte_engine #(
  parameter int DIV   = 32,
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_n,
  input  logic             xfer_n,
  input  logic             stop_n,
  input  logic             rd_wr,
  input  logic [NBITS-1:0] wr_data,
  input  logic             sda_in,
  output logic [NBITS-1:0] rd_data,
  output logic             ack,
  output logic             done_n,
  output logic             scl,
  output logic             sda_out,
  output logic             sda_oe_n
);
  logic             tick;
  logic             load;
  logic             shift;
  logic             dir_rd;
  logic             cap;
  logic             xfer_act;
  logic [NBITS-1:0] sr_q;

  i2cm_tick #(.DIV(DIV)) tick_i (
    .clk(clk), .rst(rst), .tick(tick)
  );

  i2cm_shreg #(.W(NBITS)) shreg_i (
    .clk(clk), .rst(rst), .load(load), .load_val(wr_data),
    .shift(shift), .dir_rd(dir_rd), .bit_in(sda_in), .q(sr_q)
  );

  i2cm_seq #(.NBITS(NBITS)) seq_i (
    .clk(clk), .rst(rst), .tick(tick),
    .start_n(start_n), .xfer_n(xfer_n), .stop_n(stop_n), .rd_wr(rd_wr),
    .sda_in(sda_in), .sr_msb(sr_q[NBITS-1]),
    .scl(scl), .sda_out(sda_out), .sda_oe_n(sda_oe_n), .ack(ack),
    .done_n(done_n), .load(load), .shift(shift), .dir_rd(dir_rd),
    .cap(cap), .xfer_act(xfer_act)
  );

  always_ff @(posedge clk) begin
    if (rst)                rd_data <= '0;
    else if (cap && dir_rd) rd_data <= sr_q;
  end
endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk #(
  parameter int DIV = 32
) (
  input logic clk,
  input logic rst,
  input logic start_n,
  input logic xfer_n,
  input logic stop_n,
  input logic scl,
  input logic sda_out,
  input logic sda_oe_n,
  input logic ack,
  input logic done_n,
  input logic xfer_act
);
  localparam int HW = $clog2(DIV + 1);
  localparam logic [HW-1:0] HMAX = HW'(DIV);

  logic          scl_q;
  logic [HW-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      hold  <= HMAX;
    end else begin
      scl_q <= scl;
      if (scl != scl_q)  hold <= '0;
      else if (hold < HMAX) hold <= hold + 1'b1;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (scl && sda_out && sda_oe_n && ack && done_n));

  // R3
  xfer_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_act && $past(xfer_act) && scl && $past(scl)) |-> ($stable(sda_out) && $stable(sda_oe_n)));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!done_n && !(start_n && xfer_n && stop_n)) |=> !done_n);

  // R7
  done_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_n) |-> $past(start_n && xfer_n && stop_n));

  // R10
  scl_period_chk: assert property (@(posedge clk) disable iff (rst)
    (scl != scl_q) |-> (hold >= HW'(DIV - 1)));
endmodule

bind i2cm_byte_engine i2cm_chk #(.DIV(DIV)) chk_i (
  .clk(clk), .rst(rst), .start_n(start_n), .xfer_n(xfer_n), .stop_n(stop_n),
  .scl(scl), .sda_out(sda_out), .sda_oe_n(sda_oe_n), .ack(ack),
  .done_n(done_n), .xfer_act(xfer_act)
);

// File: tb/i2cm_byte_engine_tb_top.sv
module i2cm_byte_engine_tb_top;
  localparam int DIV = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1;
  logic       start_n = 1'b1, xfer_n = 1'b1, stop_n = 1'b1, rd_wr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       sda_in;
  logic [7:0] rd_data;
  logic       ack, done_n, scl, sda_out, sda_oe_n;

  int vectors = 0;
  int errors  = 0;

  // slave model
  logic       slave_en = 1'b0;
  logic [7:0] slave_byte = 8'h00;
  logic       slave_ack = 1'b1;
  int         k = 0;

  always_comb begin
    if (!sda_oe_n)     sda_in = sda_out;
    else if (!slave_en) sda_in = 1'b1;
    else if (k < 8)    sda_in = slave_byte[7 - k];
    else               sda_in = slave_ack;
  end

  i2cm_byte_engine #(.DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .start_n(start_n), .xfer_n(xfer_n), .stop_n(stop_n),
    .rd_wr(rd_wr), .wr_data(wr_data), .sda_in(sda_in), .rd_data(rd_data),
    .ack(ack), .done_n(done_n), .scl(scl), .sda_out(sda_out), .sda_oe_n(sda_oe_n)
  );

  // bus monitor
  logic       scl_p = 1'b1, line_p = 1'b1;
  int         starts = 0, stops = 0, rises = 0;
  int         hold = 0, min_hold = 1000;
  logic [8:0] cap = '0, oeh = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (scl && scl_p && line_p && !sda_in) starts++;
      if (scl && scl_p && !line_p && sda_in) stops++;
      if (scl && !scl_p) begin
        cap = {cap[7:0], sda_in};
        oeh = {oeh[7:0], sda_oe_n};
        rises++;
      end
      if (!scl && scl_p) k++;
      if (scl != scl_p) begin
        if (hold < min_hold && hold > 0) min_hold = hold;
        hold = 1;
      end else if (hold > 0) hold++;
    end
    scl_p  = scl;
    line_p = sda_in;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_done();
    while (done_n) @(negedge clk);
  endtask

  task automatic release_and_check();
    repeat (3) @(negedge clk);
    check(done_n == 1'b0, "R7 held low while request low", done_n, 0);
    start_n = 1'b1; xfer_n = 1'b1; stop_n = 1'b1;
    @(negedge clk);
    check(done_n == 1'b1, "R7 returns high after release", done_n, 1);
  endtask

  task automatic run_op(input int op);
    @(negedge clk);
    case (op)
      0: start_n = 1'b0;
      1: xfer_n  = 1'b0;
      default: stop_n = 1'b0;
    endcase
    wait_done();
    release_and_check();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check(scl == 1'b1,      "R1 scl",      scl, 1);
    check(sda_out == 1'b1,  "R1 sda_out",  sda_out, 1);
    check(sda_oe_n == 1'b1, "R1 sda_oe_n", sda_oe_n, 1);
    check(ack == 1'b1,      "R1 ack",      ack, 1);
    check(done_n == 1'b1,   "R1 done_n",   done_n, 1);
    check(rd_data == 8'h00, "R1 rd_data",  rd_data, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_start();
    int s0 = starts;
    run_op(0);
    check(starts == s0 + 1, "R2 start condition seen", starts - s0, 1);
    check(scl == 1'b0 && sda_in == 1'b0, "R2 lines low after start", {scl, sda_in}, 0);
  endtask

  task automatic t_write(input logic [7:0] b, input logic a);
    int r0 = rises;
    wr_data = b; rd_wr = 1'b0;
    slave_en = 1'b1; slave_ack = a; k = 0;
    run_op(1);
    check(rises - r0 == 9, "R4 nine scl pulses", rises - r0, 9);
    check(cap[8:1] == b, "R3 write byte MSB first", cap[8:1], b);
    check(oeh == 9'h001, "R4 sda released on ninth pulse only", oeh, 9'h001);
    check(ack == a, "R4 ack captured", ack, a);
    slave_en = 1'b0;
  endtask

  task automatic t_read(input logic [7:0] b);
    rd_wr = 1'b1; slave_byte = b; slave_ack = 1'b1;
    slave_en = 1'b1; k = 0;
    run_op(1);
    check(rd_data == b, "R5 read byte", rd_data, b);
    check(oeh == 9'h1FF, "R5 sda released throughout", oeh, 9'h1FF);
    check(ack == 1'b1, "R4 ninth bit on read", ack, 1);
    slave_en = 1'b0; rd_wr = 1'b0;
  endtask

  task automatic t_stop();
    int p0 = stops;
    run_op(2);
    check(stops == p0 + 1, "R6 stop condition seen", stops - p0, 1);
    check(scl == 1'b1 && sda_in == 1'b1, "R6 lines high after stop", {scl, sda_in}, 3);
  endtask

  task automatic t_prio_start_stop();
    int s0 = starts;
    int p0 = stops;
    @(negedge clk);
    start_n = 1'b0; stop_n = 1'b0;
    wait_done();
    release_and_check();
    check(starts == s0 + 1, "R9 start wins over stop", starts - s0, 1);
    check(stops == p0, "R9 no stop when start wins", stops - p0, 0);
  endtask

  task automatic t_prio_xfer_stop();
    int p0 = stops;
    int r0 = rises;
    wr_data = 8'h81; rd_wr = 1'b0; slave_en = 1'b1; slave_ack = 1'b0; k = 0;
    @(negedge clk);
    xfer_n = 1'b0; stop_n = 1'b0;
    wait_done();
    release_and_check();
    check(rises - r0 == 9 && cap[8:1] == 8'h81, "R9 transfer wins over stop", cap[8:1], 8'h81);
    check(stops == p0, "R9 no stop when transfer wins", stops - p0, 0);
    slave_en = 1'b0;
  endtask

  task automatic t_ignore();
    int s0 = starts;
    int p0 = stops;
    wr_data = 8'h96; rd_wr = 1'b0; slave_en = 1'b1; slave_ack = 1'b0; k = 0;
    @(negedge clk);
    xfer_n = 1'b0;
    repeat (20) @(negedge clk);
    start_n = 1'b0; stop_n = 1'b0;
    repeat (8) @(negedge clk);
    start_n = 1'b1; stop_n = 1'b1;
    wr_data = 8'h00;
    wait_done();
    release_and_check();
    check(cap[8:1] == 8'h96, "R8 byte unaffected by busy requests", cap[8:1], 8'h96);
    check(starts == s0 && stops == p0, "R8 no extra start or stop", (starts - s0) + (stops - p0), 0);
    slave_en = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog timeout actual=%0h expected=%0h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_start();
    t_write(8'hA5, 1'b0);
    t_write(8'h3C, 1'b1);
    t_read(8'h5A);
    t_stop();
    t_prio_start_stop();
    t_prio_xfer_stop();
    t_ignore();
    t_read(8'hC3);
    t_stop();
    check(min_hold >= DIV, "R10 minimum scl level length", min_hold, DIV);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule